// File: doc/BRIEF.md
# Display Status and Line-Match Interrupt Unit

This unit keeps the byte registers that a processor uses to watch and steer a display timing engine. The timing engine supplies the current scanline number and a 2-bit phase code. The unit supplies a status byte, a line-match compare register, a control byte and two scroll bytes, all reached over a simple byte bus with separate read and write strobes.

The unit compares the incoming scanline with the compare register on every cycle and keeps the result as a match flag. Four interrupt sources can each be enabled: three phase codes and the match flag. The enabled sources are ORed into one condition. The output request is a single-cycle pulse that fires when that combined condition goes from low to high.

A read strobe latches the addressed byte into the read-data register, which it drives on the cycle after the strobe. Between reads the register holds its value.

Top module: `lcd_status_unit`

## Requirements
- R1: After reset, the control, scroll, compare and enable registers hold 0, the read-data output is 0x00 and the interrupt output is low.
- R2: Status bits 1:0 read back the phase input. The codes are 0 for horizontal blank, 1 for vertical blank, 2 for object scan and 3 for drawing.
- R3: Status bit 2 is the match flag. It reads 1 when the scanline input equals the compare register, and it follows a change of either one cycle after the change.
- R4: Status bit 7 always reads 1. Status bits 6:3 are the enables for horizontal blank (bit 3), vertical blank (bit 4), object scan (bit 5) and line match (bit 6).
- R5: A write to the status byte (0xFF41) changes only bits 6:3. Bits 2:0 keep tracking their sources and bit 7 stays 1.
- R6: Reading 0xFF44 returns the scanline input. A write to 0xFF44 changes nothing that can be read back.
- R7: The control byte (0xFF40), vertical scroll (0xFF42), horizontal scroll (0xFF43) and compare register (0xFF45) read back the last value written to them.
- R8: A read of any other address returns 0xFF. A write to any other address changes no register.
- R9: The interrupt output is a one-cycle pulse. It fires one cycle after the OR of the enabled conditions rises. While the OR stays high, further conditions that become true do not fire it again.
- R10: With its enable set, the line-match source fires on the rising edge of the match flag. With its enable clear, changes of the match flag never fire the interrupt.
- R11: The read-data output changes only on the cycle after a read strobe. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Byte bus address |
| busWrData | input | 8 | Write data |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRdData | output | 8 | Read data, valid the cycle after busRd |
| phaseIn | input | 2 | Phase code from the timing engine |
| lineIn | input | 8 | Current scanline from the timing engine (0 to 153) |
| irqPulse | output | 1 | Single-cycle interrupt request |

## Verification
The assertions take for granted that busRd and busWr are never high in the same cycle. They also assume that phaseIn and lineIn change only at clock edges, in the way a timing engine drives them. The bench drives every input on the falling clock edge and raises only one bus strobe per access, with the strobe held for one cycle. It counts interrupt pulses at the falling edge, so each single-cycle pulse is counted exactly once.

// File: rtl/lcd_status_pkg.sv
package lcd_status_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int NUM_SRC = 4;
  localparam int NUM_PHASE_SRC = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 16'hFF40;
  localparam logic [ADDR_W-1:0] A_STAT = 16'hFF41;
  localparam logic [ADDR_W-1:0] A_VSCR = 16'hFF42;
  localparam logic [ADDR_W-1:0] A_HSCR = 16'hFF43;
  localparam logic [ADDR_W-1:0] A_LINE = 16'hFF44;
  localparam logic [ADDR_W-1:0] A_CMP  = 16'hFF45;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_STAT, SEL_VSCR, SEL_HSCR, SEL_LINE, SEL_CMP, SEL_NONE
  } rd_sel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrStat;
    logic    wrVscr;
    logic    wrHscr;
    logic    wrCmp;
    logic    rdEn;
    rd_sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/lcd_status_ctrl.sv
module lcd_status_ctrl
  import lcd_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busRd,
  input  logic                  busWr,
  input  logic [1:0]            phaseIn,
  input  logic [NUM_SRC-1:0]    srcEn,
  input  logic                  matchFlag,
  output strobe_t               strb,
  output logic                  irqPulse
);
  rd_sel_e sel;
  logic [NUM_SRC-1:0] condHit;
  logic anyCond;
  logic anyCondPrev;

  always_comb begin
    case (busAddr)
      A_CTRL:  sel = SEL_CTRL;
      A_STAT:  sel = SEL_STAT;
      A_VSCR:  sel = SEL_VSCR;
      A_HSCR:  sel = SEL_HSCR;
      A_LINE:  sel = SEL_LINE;
      A_CMP:   sel = SEL_CMP;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb        = '0;
    strb.rdSel  = sel;
    strb.rdEn   = busRd;
    strb.wrCtrl = busWr && (sel == SEL_CTRL);
    strb.wrStat = busWr && (sel == SEL_STAT);
    strb.wrVscr = busWr && (sel == SEL_VSCR);
    strb.wrHscr = busWr && (sel == SEL_HSCR);
    strb.wrCmp  = busWr && (sel == SEL_CMP);
  end

  // Phase sources: enable bit i pairs with phase code i
  for (genvar gi = 0; gi < NUM_PHASE_SRC; gi++) begin : gPhaseSrc
    assign condHit[gi] = srcEn[gi] && (phaseIn == 2'(gi));
  end
  assign condHit[NUM_SRC-1] = srcEn[NUM_SRC-1] && matchFlag;
  assign anyCond = |condHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      anyCondPrev <= 1'b0;
      irqPulse    <= 1'b0;
    end else begin
      anyCondPrev <= anyCond;
      irqPulse    <= anyCond && !anyCondPrev;
    end
  end

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R9
  AST_IRQ_NEEDS_COND: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(anyCond)); // R9
  AST_WR_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl, strb.wrStat, strb.wrVscr, strb.wrHscr, strb.wrCmp})); // R8
endmodule

// File: rtl/lcd_status_dp.sv
module lcd_status_dp
  import lcd_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [BYTE_W-1:0]     lineIn,
  input  logic [1:0]            phaseIn,
  output logic [BYTE_W-1:0]     rdData,
  output logic [NUM_SRC-1:0]    srcEn,
  output logic                  matchFlag
);
  logic [BYTE_W-1:0] ctrlReg, vscrReg, hscrReg, cmpReg;
  logic [BYTE_W-1:0] statByte;
  logic [BYTE_W-1:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      vscrReg   <= '0;
      hscrReg   <= '0;
      cmpReg    <= '0;
      srcEn     <= '0;
      matchFlag <= 1'b0;
    end else begin
      if (strb.wrCtrl) ctrlReg <= wrData;
      if (strb.wrVscr) vscrReg <= wrData;
      if (strb.wrHscr) hscrReg <= wrData;
      if (strb.wrCmp)  cmpReg  <= wrData;
      if (strb.wrStat) srcEn   <= wrData[6:3];
      matchFlag <= (lineIn == cmpReg);
    end
  end

  assign statByte = {1'b1, srcEn, matchFlag, phaseIn};

  always_comb begin
    case (strb.rdSel)
      SEL_CTRL: rdMux = ctrlReg;
      SEL_STAT: rdMux = statByte;
      SEL_VSCR: rdMux = vscrReg;
      SEL_HSCR: rdMux = hscrReg;
      SEL_LINE: rdMux = lineIn;
      SEL_CMP:  rdMux = cmpReg;
      default:  rdMux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdMux;
  end

  AST_STAT_TOP_BIT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == SEL_STAT) |=> rdData[7]); // R4
  AST_EN_ONLY_ON_STAT_WR: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStat |=> $stable(srcEn)); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData)); // R11
  AST_UNMAPPED_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == SEL_NONE) |=> (rdData == 8'hFF)); // R8
endmodule

// File: rtl/lcd_status_unit.sv
module lcd_status_unit
  import lcd_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [BYTE_W-1:0]     busWrData,
  input  logic                  busRd,
  input  logic                  busWr,
  output logic [BYTE_W-1:0]     busRdData,
  input  logic [1:0]            phaseIn,
  input  logic [BYTE_W-1:0]     lineIn,
  output logic                  irqPulse
);
  strobe_t            strb;
  logic [NUM_SRC-1:0] srcEn;
  logic               matchFlag;

  lcd_status_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .phaseIn(phaseIn), .srcEn(srcEn), .matchFlag(matchFlag),
    .strb(strb), .irqPulse(irqPulse)
  );

  lcd_status_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData), .lineIn(lineIn),
    .phaseIn(phaseIn), .rdData(busRdData), .srcEn(srcEn), .matchFlag(matchFlag)
  );
endmodule

// File: tb/test_lcd_status_unit.sv
module test_lcd_status_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busRdData;
  logic [1:0]  phaseIn = 2'd0;
  logic [7:0]  lineIn = 8'd0;
  logic        irqPulse;

  int nChecks = 0;
  int nFails = 0;
  int irqCount = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  lcd_status_unit i_lcd_status_unit (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .busWr(busWr), .busRdData(busRdData),
    .phaseIn(phaseIn), .lineIn(lineIn), .irqPulse(irqPulse)
  );

  always @(negedge clk) if (irqPulse) irqCount++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic testReset();
    check("R1 rdData", busRdData, 8'h00);
    check("R1 irq", {7'd0, irqPulse}, 8'h00);
    busRead(16'hFF40, rv); check("R1 ctrl", rv, 8'h00);
    busRead(16'hFF45, rv); check("R1 cmp", rv, 8'h00);
  endtask

  task automatic testRegs();
    busWrite(16'hFF40, 8'h91); busWrite(16'hFF42, 8'h3C);
    busWrite(16'hFF43, 8'hA5); busWrite(16'hFF45, 8'h77);
    busRead(16'hFF40, rv); check("R7 ctrl", rv, 8'h91);
    busRead(16'hFF42, rv); check("R7 vscroll", rv, 8'h3C);
    busRead(16'hFF43, rv); check("R7 hscroll", rv, 8'hA5);
    busRead(16'hFF45, rv); check("R7 cmp", rv, 8'h77);
  endtask

  task automatic testLine();
    lineIn = 8'd153; idle(1);
    busRead(16'hFF44, rv); check("R6 line read", rv, 8'd153);
    busWrite(16'hFF44, 8'h12);
    busRead(16'hFF44, rv); check("R6 line write ignored", rv, 8'd153);
    busRead(16'hFF45, rv); check("R6 cmp untouched", rv, 8'h77);
  endtask

  task automatic testStatus();
    // cmp = 0x77, line = 153: no match
    for (int p = 0; p < 4; p++) begin
      phaseIn = 2'(p); idle(1);
      busRead(16'hFF41, rv); check("R2 phase", rv, {6'b100000, 2'(p)});
    end
    phaseIn = 2'd1;
    busWrite(16'hFF41, 8'hFF);
    busRead(16'hFF41, rv); check("R5 stat all ones", rv, 8'hF9);
    busWrite(16'hFF41, 8'h28); // enables: hblank, object scan
    busRead(16'hFF41, rv); check("R4 enable order", rv, 8'hA9);
    busWrite(16'hFF41, 8'h00);
    lineIn = 8'h77; idle(2);
    busRead(16'hFF41, rv); check("R3 match set", rv, 8'h85);
    busWrite(16'hFF41, 8'h07);
    busRead(16'hFF41, rv); check("R5 low bits kept", rv, 8'h85);
    busWrite(16'hFF45, 8'h78); idle(2);
    busRead(16'hFF41, rv); check("R3 match cleared", rv, 8'h81);
  endtask

  task automatic testUnmapped();
    busWrite(16'hFF46, 8'h55);
    busWrite(16'h0041, 8'h66);
    busRead(16'hFF46, rv); check("R8 unmapped read", rv, 8'hFF);
    busRead(16'hFF40, rv); check("R8 ctrl untouched", rv, 8'h91);
    busRead(16'hFF41, rv); check("R8 stat untouched", rv, 8'h81);
    busRead(16'hFF42, rv);
    idle(3); check("R11 read data holds", busRdData, 8'h3C);
  endtask

  task automatic testIrqPhase();
    phaseIn = 2'd3; lineIn = 8'd0; busWrite(16'hFF45, 8'd9);
    busWrite(16'hFF41, 8'h08); idle(3);
    irqCount = 0;
    phaseIn = 2'd0; idle(4);
    check("R9 hblank pulse", 8'(irqCount), 8'd1);
    phaseIn = 2'd2; idle(2); phaseIn = 2'd0; idle(4);
    check("R9 second pulse", 8'(irqCount), 8'd2);
    phaseIn = 2'd1; idle(4);
    check("R9 disabled phase quiet", 8'(irqCount), 8'd2);
  endtask

  task automatic testIrqMatch();
    phaseIn = 2'd3; lineIn = 8'd0;
    busWrite(16'hFF41, 8'h00); idle(3);
    irqCount = 0;
    lineIn = 8'd9; idle(4); lineIn = 8'd10; idle(4);
    check("R10 match disabled", 8'(irqCount), 8'd0);
    busWrite(16'hFF41, 8'h40); idle(3);
    lineIn = 8'd9; idle(4);
    check("R10 match pulse", 8'(irqCount), 8'd1);
    lineIn = 8'd10; idle(3);
    busWrite(16'hFF41, 8'h48); idle(3);
    irqCount = 0;
    phaseIn = 2'd0; idle(4);
    check("R9 hblank first", 8'(irqCount), 8'd1);
    lineIn = 8'd9; idle(4);
    check("R9 overlap no retrigger", 8'(irqCount), 8'd1);
    phaseIn = 2'd3; idle(3); lineIn = 8'd10; idle(3); lineIn = 8'd9; idle(4);
    check("R10 match after low", 8'(irqCount), 8'd2);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testRegs();
    testLine();
    testStatus();
    testUnmapped();
    testIrqPhase();
    testIrqMatch();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #800000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule